// File: doc/BRIEF.md
# Half-Word Page Table Walker

This block fills a single translation entry on a translation miss. It takes a virtual address, a reference type (read or write) and a table selector (user or executive). From the executive or user process-table base and the virtual page number it forms the physical word address of the page-table word. It issues one memory read for that word, picks the 18-bit half that belongs to the page, checks the access rights and returns an expanded translation entry together with a page-fail word.

Two variants of a request change what the block commits to. A probe request reports extra access information in the fail word and never traps or fills. A console request also never traps or fills, so a debugger can look at a translation without disturbing the table. If the table word lies beyond installed memory, no read is issued and a physical nonexistent-memory failure is reported instead.

Top module: `hw_ptwalk`

## Requirements
- R1: For a user page, the table word address is `upt_base + USR_MAP_OFF + (vpn >> 1)`, where `vpn = vaddr[17:9]`. An even page takes bits [35:18] of the word and an odd page takes bits [17:0].
- R2: For an executive page, pages below 0o340 read `ept_base + EXE_LO_OFF + (vpn >> 1)`. Pages 0o340 to 0o377 read `upt_base + USR_MID_OFF + ((vpn - 0o340) >> 1)`. Pages 0o400 and above read `ept_base + EXE_HI_OFF + ((vpn - 0o400) >> 1)`. Half selection follows R1.
- R3: Within an entry, bit 17 means accessible, bit 16 writable, bit 15 software and bit 14 cacheable, and bits [10:0] hold the physical page number. Access is granted when bit 17 is set and the reference is a read or bit 16 is set. On a grant, `xpte_valid` is 1, `xpte_wr` equals bit 16 and `xpte_ppn` equals bits [10:0]. On a denial all three are zero.
- R4: The fail word for a virtual reference has these bits: 35 set, 34 the user selector, 33 the write flag, 32 entry bit 17, and 31 set when entry bits 15 and 17 are both set. Bits [17:0] hold the virtual address and every other bit is zero.
- R5: In probe mode, the fail word also has bit 31 equal to entry bit 15, bit 30 equal to entry bit 16 and bit 29 equal to entry bit 14. Probe mode never asserts `fill_we` or `trap`.
- R6: In console mode, `fill_we` and `trap` stay low. Otherwise, with neither probe nor console set, a grant asserts `fill_we` and a denial asserts `trap`.
- R7: When the table word address is at or above `MEM_WORDS`, no memory read is issued, and `nxm` and `granted` read 1 and 0. The fail word has bits 28, 27 and 34 (the user selector) set and bits [19:0] equal to the table word address, with all other bits zero. `trap` is asserted unless probe or console is set.
- R8: Each fill makes exactly one memory read handshake, or none under R7. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R9: Out of reset, `req_ready` is 1 and `done`, `mem_req_valid`, `fill_we` and `fail_word` are 0. `done` pulses for one cycle per fill, and the result outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_user | input | 1 | 1 selects the user table, 0 the executive table |
| req_write | input | 1 | Write reference |
| req_probe | input | 1 | Probe mode |
| req_console | input | 1 | Console mode |
| req_vaddr | input | VA_W | Virtual address |
| ept_base | input | PA_W | Executive process-table base |
| upt_base | input | PA_W | User process-table base |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Table word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 36 | Read data |
| done | output | 1 | One-cycle completion pulse |
| granted | output | 1 | Access granted |
| fill_we | output | 1 | Write the expanded entry into the table |
| trap | output | 1 | Raise a page fail |
| nxm | output | 1 | Table word lies beyond memory |
| xpte_valid | output | 1 | Expanded entry valid |
| xpte_wr | output | 1 | Expanded entry writable |
| xpte_ppn | output | PA_W-PG_W | Expanded entry physical page |
| fail_word | output | 36 | Page-fail word |

## Verification
The bench sweeps all 512 pages across both tables, both reference types and all three modes, with two user bases. The second user base pushes the upper user pages and the whole executive middle range past installed memory. The range edges 0o337/0o340 and 0o377/0o400 catch an off-by-one split, which would read a word one table away. Adjacent even and odd pages catch a swapped half, which would return the neighbour's rights. Memory stalls check that the request address holds steady. The out-of-range cases catch a walker that still issues a read or that builds a virtual fail word.

// File: rtl/hw_ptwalk_pkg.sv
package hw_ptwalk_pkg;

  localparam int WORD_W = 36;
  localparam int ENT_W  = 18;

  // entry bit positions
  localparam int E_ACC = 17;
  localparam int E_WR  = 16;
  localparam int E_SW  = 15;
  localparam int E_CA  = 14;

  // fail word bit positions
  localparam int F_VIRT = 35;
  localparam int F_USER = 34;
  localparam int F_WREF = 33;
  localparam int F_ACC  = 32;
  localparam int F_SW   = 31;
  localparam int F_WR   = 30;
  localparam int F_CA   = 29;
  localparam int F_NXM  = 28;
  localparam int F_PHYS = 27;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FAULT = 2'd3
  } pw_state_e;

  function automatic logic [ENT_W-1:0] pick_half(input logic [WORD_W-1:0] w, input logic odd);
    return odd ? w[ENT_W-1:0] : w[WORD_W-1:ENT_W];
  endfunction

  function automatic logic access_ok(input logic [ENT_W-1:0] e, input logic is_write);
    return e[E_ACC] && (!is_write || e[E_WR]);
  endfunction

endpackage

// File: rtl/hw_ptwalk_addr.sv
module hw_ptwalk_addr #(
  parameter int VPN_W       = 9,
  parameter int PA_W        = 20,
  parameter int MEM_WORDS   = 1 << 18,
  parameter int USR_MAP_OFF = 0,
  parameter int USR_MID_OFF = 'o400,
  parameter int EXE_LO_OFF  = 'o600,
  parameter int EXE_HI_OFF  = 'o200,
  parameter int SPLIT_LO    = 'o340,
  parameter int SPLIT_HI    = 'o400
) (
  input  logic             is_user,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  ept_base,
  input  logic [PA_W-1:0]  upt_base,
  output logic [PA_W-1:0]  ent_addr,
  output logic             beyond_mem
);

  localparam logic [VPN_W-1:0] LO_V  = VPN_W'(SPLIT_LO);
  localparam logic [VPN_W-1:0] HI_V  = VPN_W'(SPLIT_HI);
  localparam logic [PA_W:0]    LIMIT = (PA_W+1)'(MEM_WORDS);

  logic [PA_W-1:0]  base;
  logic [PA_W-1:0]  off;
  logic [VPN_W-1:0] idx;

  always_comb begin
    if (is_user) begin
      base = upt_base; off = PA_W'(USR_MAP_OFF); idx = vpn;
    end else if (vpn < LO_V) begin
      base = ept_base; off = PA_W'(EXE_LO_OFF);  idx = vpn;
    end else if (vpn < HI_V) begin
      base = upt_base; off = PA_W'(USR_MID_OFF); idx = vpn - LO_V;
    end else begin
      base = ept_base; off = PA_W'(EXE_HI_OFF);  idx = vpn - HI_V;
    end
    ent_addr = base + off + PA_W'(idx >> 1);
  end

  assign beyond_mem = {1'b0, ent_addr} >= LIMIT;

endmodule

// File: rtl/hw_ptwalk_decide.sv
module hw_ptwalk_decide
  import hw_ptwalk_pkg::*;
#(
  parameter int VA_W  = 18,
  parameter int PA_W  = 20,
  parameter int PPN_W = 11
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic              is_user,
  input  logic              is_write,
  input  logic              probe,
  input  logic              console,
  input  logic              fetch_nxm,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PA_W-1:0]   fetch_addr,
  output logic              grant,
  output logic              fill_we,
  output logic              trap,
  output logic              xv,
  output logic              xw,
  output logic [PPN_W-1:0]  xppn,
  output logic [WORD_W-1:0] fword
);

  logic quiet;
  logic unused_ent;

  assign quiet      = probe || console;
  assign unused_ent = ^entry;
  assign grant      = !fetch_nxm && access_ok(entry, is_write);
  assign fill_we    = grant && !quiet;
  assign trap       = !grant && !quiet;
  assign xv         = grant;
  assign xw         = grant && entry[E_WR];
  assign xppn       = grant ? entry[PPN_W-1:0] : '0;

  always_comb begin
    fword = '0;
    fword[F_USER] = is_user;
    if (fetch_nxm) begin
      fword[F_NXM]      = 1'b1;
      fword[F_PHYS]     = 1'b1;
      fword[PA_W-1:0]   = fetch_addr;
    end else begin
      fword[F_VIRT]     = 1'b1;
      fword[F_WREF]     = is_write;
      fword[F_ACC]      = entry[E_ACC];
      fword[F_SW]       = entry[E_SW] && (entry[E_ACC] || probe);
      fword[F_WR]       = probe && entry[E_WR];
      fword[F_CA]       = probe && entry[E_CA];
      fword[VA_W-1:0]   = vaddr;
    end
  end

endmodule

// File: rtl/hw_ptwalk.sv
module hw_ptwalk
  import hw_ptwalk_pkg::*;
#(
  parameter int VA_W        = 18,
  parameter int PG_W        = 9,
  parameter int PA_W        = 20,
  parameter int MEM_WORDS   = 1 << 18,
  parameter int USR_MAP_OFF = 0,
  parameter int USR_MID_OFF = 'o400,
  parameter int EXE_LO_OFF  = 'o600,
  parameter int EXE_HI_OFF  = 'o200,
  parameter int SPLIT_LO    = 'o340,
  parameter int SPLIT_HI    = 'o400,
  localparam int VPN_W      = VA_W - PG_W,
  localparam int PPN_W      = PA_W - PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_user,
  input  logic              req_write,
  input  logic              req_probe,
  input  logic              req_console,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   ept_base,
  input  logic [PA_W-1:0]   upt_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              granted,
  output logic              fill_we,
  output logic              trap,
  output logic              nxm,
  output logic              xpte_valid,
  output logic              xpte_wr,
  output logic [PPN_W-1:0]  xpte_ppn,
  output logic [WORD_W-1:0] fail_word
);

  pw_state_e state_q, state_d;

  logic              r_user, r_write, r_probe, r_console;
  logic [VA_W-1:0]   r_vaddr;
  logic [PA_W-1:0]   r_addr;

  logic [PA_W-1:0]   calc_addr;
  logic              calc_beyond;

  // named internal events
  logic accept, rd_fire, rsp_take, fault_take, result_load;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = r_addr;
  assign rd_fire       = mem_req_valid && mem_req_ready;
  assign rsp_take      = (state_q == ST_WAIT) && mem_rsp_valid;
  assign fault_take    = (state_q == ST_FAULT);
  assign result_load   = rsp_take || fault_take;

  hw_ptwalk_addr #(
    .VPN_W(VPN_W), .PA_W(PA_W), .MEM_WORDS(MEM_WORDS),
    .USR_MAP_OFF(USR_MAP_OFF), .USR_MID_OFF(USR_MID_OFF),
    .EXE_LO_OFF(EXE_LO_OFF), .EXE_HI_OFF(EXE_HI_OFF),
    .SPLIT_LO(SPLIT_LO), .SPLIT_HI(SPLIT_HI)
  ) u_addr (
    .is_user   (req_user),
    .vpn       (req_vaddr[VA_W-1:PG_W]),
    .ept_base  (ept_base),
    .upt_base  (upt_base),
    .ent_addr  (calc_addr),
    .beyond_mem(calc_beyond)
  );

  logic [ENT_W-1:0]  entry_sel;
  logic              d_grant, d_fill, d_trap, d_xv, d_xw;
  logic [PPN_W-1:0]  d_ppn;
  logic [WORD_W-1:0] d_fword;

  assign entry_sel = fault_take ? '0 : pick_half(mem_rsp_data, r_vaddr[PG_W]);

  hw_ptwalk_decide #(.VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W)) u_decide (
    .entry     (entry_sel),
    .is_user   (r_user),
    .is_write  (r_write),
    .probe     (r_probe),
    .console   (r_console),
    .fetch_nxm (fault_take),
    .vaddr     (r_vaddr),
    .fetch_addr(r_addr),
    .grant     (d_grant),
    .fill_we   (d_fill),
    .trap      (d_trap),
    .xv        (d_xv),
    .xw        (d_xw),
    .xppn      (d_ppn),
    .fword     (d_fword)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = calc_beyond ? ST_FAULT : ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      r_user    <= 1'b0;
      r_write   <= 1'b0;
      r_probe   <= 1'b0;
      r_console <= 1'b0;
      r_vaddr   <= '0;
      r_addr    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        r_user    <= req_user;
        r_write   <= req_write;
        r_probe   <= req_probe;
        r_console <= req_console;
        r_vaddr   <= req_vaddr;
        r_addr    <= calc_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      granted    <= 1'b0;
      fill_we    <= 1'b0;
      trap       <= 1'b0;
      nxm        <= 1'b0;
      xpte_valid <= 1'b0;
      xpte_wr    <= 1'b0;
      xpte_ppn   <= '0;
      fail_word  <= '0;
    end else begin
      done <= result_load;
      if (result_load) begin
        granted    <= d_grant;
        fill_we    <= d_fill;
        trap       <= d_trap;
        nxm        <= fault_take;
        xpte_valid <= d_xv;
        xpte_wr    <= d_xw;
        xpte_ppn   <= d_ppn;
        fail_word  <= d_fword;
      end
    end
  end

  // read handshakes since the last accepted request, kept for the checks below
  logic [1:0] reads_in_fill;
  always_ff @(posedge clk) begin
    if (!rst_n)       reads_in_fill <= '0;
    else if (accept)  reads_in_fill <= '0;
    else if (rd_fire && reads_in_fill != 2'd3) reads_in_fill <= reads_in_fill + 2'd1;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reads_in_fill == (nxm ? 2'd0 : 2'd1));

  assert_fill_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && fill_we |-> granted && xpte_valid && !trap);

  assert_quiet_modes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_load && (r_probe || r_console) |=> !fill_we && !trap);

  assert_nxm_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && nxm |-> !granted && fail_word[F_NXM] && !fail_word[F_VIRT]);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_load |=> !done && $stable(fail_word) && $stable(granted));

endmodule

// File: tb/hw_ptwalk_tb.sv
module hw_ptwalk_tb;

  localparam int VA_W = 18, PG_W = 9, PA_W = 20, PPN_W = 11;
  localparam int MEMW = 1 << 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 0, req_user = 0, req_write = 0, req_probe = 0, req_console = 0;
  logic [VA_W-1:0]   req_vaddr = '0;
  logic [PA_W-1:0]   ept_base = '0, upt_base = '0;
  logic              mem_req_ready = 0, mem_rsp_valid = 0;
  logic [35:0]       mem_rsp_data = '0;
  logic              req_ready, mem_req_valid, done, granted, fill_we, trap, nxm, xpte_valid, xpte_wr;
  logic [PA_W-1:0]   mem_req_addr;
  logic [PPN_W-1:0]  xpte_ppn;
  logic [35:0]       fail_word;

  hw_ptwalk #(
    .VA_W(VA_W), .PG_W(PG_W), .PA_W(PA_W), .MEM_WORDS(MEMW),
    .USR_MAP_OFF(0), .USR_MID_OFF('o400), .EXE_LO_OFF('o600), .EXE_HI_OFF('o200),
    .SPLIT_LO('o340), .SPLIT_HI('o400)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_user(req_user), .req_write(req_write), .req_probe(req_probe),
    .req_console(req_console), .req_vaddr(req_vaddr), .ept_base(ept_base),
    .upt_base(upt_base), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .granted(granted), .fill_we(fill_we), .trap(trap), .nxm(nxm),
    .xpte_valid(xpte_valid), .xpte_wr(xpte_wr), .xpte_ppn(xpte_ppn), .fail_word(fail_word)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory contents: a multiplicative hash of the address
  function automatic logic [35:0] mw(input logic [PA_W-1:0] a);
    logic [63:0] p;
    p = {44'd0, a} * 64'h9E3779B97F4A7C15;
    return p[63:28];
  endfunction

  function automatic logic [PA_W-1:0] exp_addr(input logic usr, input logic [8:0] vpn,
                                                input logic [PA_W-1:0] eb, input logic [PA_W-1:0] ub);
    int v;
    v = int'(vpn);
    if (usr)            return ub + PA_W'(v / 2);                           // R1
    else if (v < 224)   return eb + PA_W'(384 + v / 2);                     // R2 low
    else if (v < 256)   return ub + PA_W'(256 + (v - 224) / 2);             // R2 middle
    else                return eb + PA_W'(128 + (v - 256) / 2);             // R2 high
  endfunction

  task automatic run_fill(input logic usr, input logic wr, input logic prb, input logic con,
                          input logic [8:0] vpn, input logic [PA_W-1:0] ub);
    logic [17:0]     va;
    logic [PA_W-1:0] ea, first_addr;
    logic            enx, hs, got, seen, ok_g;
    logic [17:0]     e;
    logic [35:0]     fw;
    int              rd, stall;
    va = {vpn, (vpn * 9'd7) ^ 9'o125};
    ea = exp_addr(usr, vpn, 20'h1_0000, ub);
    enx = ({1'b0, ea} >= 21'(MEMW));
    e = enx ? 18'd0 : (vpn[0] ? mw(ea)[17:0] : mw(ea)[35:18]);
    @(negedge clk);
    ept_base = 20'h1_0000; upt_base = ub;
    req_valid = 1; req_user = usr; req_write = wr; req_probe = prb; req_console = con; req_vaddr = va;
    stall = int'(vpn) % 3; rd = 0; hs = 0; got = 0; seen = 0; first_addr = '0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      req_valid = 0; mem_rsp_valid = 0;
      if (done) begin
        got = 1; mem_req_ready = 0;
      end else if (hs) begin
        hs = 0; mem_req_ready = 0; mem_rsp_valid = 1; mem_rsp_data = mw(first_addr);
      end else if (mem_req_valid) begin
        if (seen) chk(mem_req_addr == first_addr, "R8 address held while stalled", 64'(mem_req_addr), 64'(first_addr));
        first_addr = mem_req_addr; seen = 1;
        if (stall > 0) begin stall--; mem_req_ready = 0; end
        else begin mem_req_ready = 1; rd++; hs = 1; end
      end
    end
    chk(got, "R9 done reached", 64'(got), 64'd1);
    if (!got) return;
    chk(rd == (enx ? 0 : 1), "R8 R7 read count", 64'(rd), enx ? 64'd0 : 64'd1);
    if (!enx) chk(first_addr == ea, usr ? "R1 table word address" : "R2 table word address",
                  64'(first_addr), 64'(ea));
    ok_g = !enx && e[17] && (!wr || e[16]);
    chk(nxm == enx, "R7 nxm flag", 64'(nxm), 64'(enx));
    chk(granted == ok_g, "R3 grant", 64'(granted), 64'(ok_g));
    chk({xpte_valid, xpte_wr, xpte_ppn} == (ok_g ? {1'b1, e[16], e[10:0]} : 13'd0),
        "R3 expanded entry", 64'({xpte_valid, xpte_wr, xpte_ppn}),
        64'(ok_g ? {1'b1, e[16], e[10:0]} : 13'd0));
    chk(fill_we == (ok_g && !prb && !con), prb ? "R5 fill" : "R6 fill", 64'(fill_we), 64'(ok_g && !prb && !con));
    chk(trap == (!ok_g && !prb && !con), prb ? "R5 trap" : (enx ? "R7 trap" : "R6 trap"),
        64'(trap), 64'(!ok_g && !prb && !con));
    fw = '0;
    fw[34] = usr;
    if (enx) begin
      fw[28] = 1; fw[27] = 1; fw[19:0] = ea;
    end else begin
      fw[35] = 1; fw[33] = wr; fw[32] = e[17];
      fw[31] = prb ? e[15] : (e[15] & e[17]);
      fw[30] = prb & e[16]; fw[29] = prb & e[14];
      fw[17:0] = va;
    end
    chk(fail_word == fw, enx ? "R7 fail word" : (prb ? "R5 fail word" : "R4 fail word"),
        64'(fail_word), 64'(fw));
    @(negedge clk);
    chk(!done && fail_word == fw, "R9 pulse and hold", 64'({done, fail_word}), 64'(fw));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R9 reset req_ready", 64'(req_ready), 64'd1);
    chk(!done && !mem_req_valid && !fill_we && fail_word == 0, "R9 reset outputs",
        64'({done, mem_req_valid, fill_we, fail_word}), 64'd0);
    for (int bsel = 0; bsel < 2; bsel++)
      for (int m = 0; m < 3; m++)
        for (int u = 0; u < 2; u++)
          for (int w = 0; w < 2; w++)
            for (int v = 0; v < 512; v++)
              run_fill(u[0], w[0], m == 1, m == 2, 9'(v),
                       bsel == 0 ? 20'h2_0000 : 20'(MEMW - 'o200));
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 195000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule